// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block works beside a small 8-bit processor core and handles the hardware side of entering an interrupt. While idle it samples a reset request, a hardware-interrupt request, the core's global interrupt-enable flag and a 32-bit vector of pending interrupt sources. When it accepts one of these, it takes a snapshot of the current program counter and stack pointer and fixes which vector it will use. It then writes the return address to a byte-wide stack, one byte per cycle, through a plain write port.

In the last cycle of the sequence it presents the new program counter, which is a word address into the vector table, together with the updated stack pointer. In that same cycle it pulses a clear for the global enable flag and a one-hot clear for the pending source it serviced. The core applies all of these when `done` is high.

The return-address width (1, 2 or 3 bytes), the vector-table spacing (two words when long jumps exist, otherwise one) and the table base are parameters.

Top module: `irq_entry_seq`

## Requirements
- R1: When several sources are pending, the lowest-numbered set bit of `pendIn` wins. On completion `pendClr` has exactly that bit set and no other bit.
- R2: A hardware source at bit i uses vector number i+1. An accepted reset uses vector number 0.
- R3: `pcOut` equals VEC_BASE + vector x entry size, truncated to 8*PC_BYTES bits. The entry size is 2 when LONG_JUMP=1 and 1 otherwise.
- R4: The return address is written least significant byte first. Push k (counting from 0) carries bits [8k+7:8k] of the sampled `pcIn`.
- R5: Each push writes at the current stack pointer, starting at the sampled `spIn`, and the pointer then drops by one. At completion `spOut` equals `spIn` - PC_BYTES.
- R6: Exactly PC_BYTES pushes occur, one per cycle, in the PC_BYTES cycles right after the acceptance edge.
- R7: `gieClr` pulses for one cycle, together with `pcLoad`.
- R8: A hardware interrupt is accepted only when `hwReq`, `gieIn` and at least one `pendIn` bit are all high. Otherwise no sequence starts.
- R9: An accepted reset request (it needs `gieIn` high) wins over a hardware request in the same cycle. It uses vector 0 and clears no pending bit.
- R10: `busy` is high from the cycle after acceptance through the completion cycle. Requests and changes on `pcIn`, `spIn` and `pendIn` while busy do not affect the sequence in progress.
- R11: After reset, `busy`, `done`, `memWe`, `pcLoad`, `gieClr` and `pendClr` are all low. `done` and `pcLoad` are a one-cycle pulse in the cycle after the last push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resetReq | input | 1 | Reset entry request |
| hwReq | input | 1 | Hardware interrupt request |
| gieIn | input | 1 | Global interrupt-enable flag of the core |
| pendIn | input | SRC_W | Pending interrupt sources |
| pcIn | input | 8*PC_BYTES | Return program counter |
| spIn | input | SP_W | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| memWe | output | 1 | Stack write strobe |
| memAddr | output | SP_W | Stack write address |
| memData | output | 8 | Stack write byte |
| pcLoad | output | 1 | Load strobe for the new program counter |
| pcOut | output | 8*PC_BYTES | Vector address (word address) |
| spOut | output | SP_W | Stack pointer after the pushes |
| gieClr | output | 1 | Clear strobe for the global enable flag |
| pendClr | output | SRC_W | One-hot clear of the serviced source |

## Verification
The hardest situation to reach is a new request arriving while a sequence is still running. It has to be shown that the request, the new pending vector and the new PC and SP values leave the running sequence untouched. To get there, the stimulus raises reset and hardware requests with a different lowest pending bit and inverted PC/SP values in the first push cycle, then withdraws them before any instance returns to idle. Three instances with 1-, 2- and 3-byte return addresses and different table spacings share these inputs, so push order, pointer steps and vector arithmetic are checked for every width against the same event.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_FIN  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch inputs, acceptance edge
    logic takeReset;  // accepted request is a reset
    logic push;       // one stack byte this cycle
    logic finish;     // completion cycle
  } seqStrobe_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int PC_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resetReq,
  input  logic       hwReq,
  input  logic       gieIn,
  input  logic       anyPend,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(PC_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(PC_BYTES - 1);

  seqState_t        state;
  logic [CNT_W-1:0] byteCnt;
  logic             acceptReset, acceptHw;

  always_comb begin
    acceptReset = resetReq && gieIn;
    acceptHw    = hwReq && gieIn && anyPend;
    strb        = '0;
    if (state == SEQ_IDLE) begin
      strb.capture   = acceptReset || acceptHw;
      strb.takeReset = acceptReset;
    end
    strb.push   = (state == SEQ_PUSH);
    strb.finish = (state == SEQ_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      byteCnt <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (strb.capture) begin
          state   <= SEQ_PUSH;
          byteCnt <= '0;
        end
        SEQ_PUSH: begin
          byteCnt <= byteCnt + 1'b1;
          if (byteCnt == LAST_BYTE) state <= SEQ_FIN;
        end
        SEQ_FIN: state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SEQ_IDLE);
  assign done = strb.finish;

  // push counter for checking only
  logic [CNT_W-1:0] pushSeen;
  always_ff @(posedge clk) begin
    if (!rst_n)            pushSeen <= '0;
    else if (strb.capture) pushSeen <= '0;
    else if (strb.push)    pushSeen <= pushSeen + 1'b1;
  end

  p_push_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pushSeen == CNT_W'(PC_BYTES));

  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/irq_entry_dpath.sv
module irq_entry_dpath
  import irq_entry_pkg::*;
#(
  parameter int SRC_W     = 32,
  parameter int PC_BYTES  = 3,
  parameter int SP_W      = 16,
  parameter bit LONG_JUMP = 1'b1,
  parameter int VEC_BASE  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seqStrobe_t            strb,
  input  logic [8*PC_BYTES-1:0] pcIn,
  input  logic [SP_W-1:0]       spIn,
  input  logic [SRC_W-1:0]      pendIn,
  output logic                  anyPend,
  output logic                  memWe,
  output logic [SP_W-1:0]       memAddr,
  output logic [7:0]            memData,
  output logic                  pcLoad,
  output logic [8*PC_BYTES-1:0] pcOut,
  output logic [SP_W-1:0]       spOut,
  output logic                  gieClr,
  output logic [SRC_W-1:0]      pendClr
);

  localparam int PC_W        = 8 * PC_BYTES;
  localparam int VEC_W       = $clog2(SRC_W + 1) + 1;
  localparam int ENTRY_WORDS = LONG_JUMP ? 2 : 1;

  logic [PC_W-1:0]  pcShift;
  logic [SP_W-1:0]  spReg;
  logic [VEC_W-1:0] vecReg;
  logic [SRC_W-1:0] maskReg;
  logic [VEC_W-1:0] lowIdx;
  logic [SRC_W-1:0] lowMask;
  logic [31:0]      target;

  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    lowIdx = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (pendIn[i]) lowIdx = VEC_W'(i);
    end
    lowMask = anyPend ? (SRC_W'(1) << lowIdx) : '0;
  end

  assign anyPend = |pendIn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcShift <= '0;
      spReg   <= '0;
      vecReg  <= '0;
      maskReg <= '0;
    end else if (strb.capture) begin
      pcShift <= pcIn;
      spReg   <= spIn;
      vecReg  <= strb.takeReset ? '0 : lowIdx + 1'b1;
      maskReg <= strb.takeReset ? '0 : lowMask;
    end else if (strb.push) begin
      pcShift <= PC_W'(pcShift >> 8);
      spReg   <= spReg - 1'b1;
    end
  end

  assign target  = 32'(VEC_BASE) + 32'(vecReg) * 32'(ENTRY_WORDS);
  assign memWe   = strb.push;
  assign memAddr = spReg;
  assign memData = pcShift[7:0];
  assign pcLoad  = strb.finish;
  assign pcOut   = target[PC_W-1:0];
  assign spOut   = spReg;
  assign gieClr  = strb.finish;
  assign pendClr = strb.finish ? maskReg : '0;

  p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && $past(memWe)) |-> memAddr == $past(memAddr) - 1'b1);

  p_clr_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pendClr));

  p_gie_with_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gieClr) |-> $past(memWe));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int SRC_W     = 32,
  parameter int PC_BYTES  = 3,
  parameter int SP_W      = 16,
  parameter bit LONG_JUMP = 1'b1,
  parameter int VEC_BASE  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  resetReq,
  input  logic                  hwReq,
  input  logic                  gieIn,
  input  logic [SRC_W-1:0]      pendIn,
  input  logic [8*PC_BYTES-1:0] pcIn,
  input  logic [SP_W-1:0]       spIn,
  output logic                  busy,
  output logic                  done,
  output logic                  memWe,
  output logic [SP_W-1:0]       memAddr,
  output logic [7:0]            memData,
  output logic                  pcLoad,
  output logic [8*PC_BYTES-1:0] pcOut,
  output logic [SP_W-1:0]       spOut,
  output logic                  gieClr,
  output logic [SRC_W-1:0]      pendClr
);

  seqStrobe_t strb;
  logic       anyPend;

  irq_entry_ctrl #(.PC_BYTES(PC_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .hwReq(hwReq),
    .gieIn(gieIn), .anyPend(anyPend), .strb(strb), .busy(busy), .done(done)
  );

  irq_entry_dpath #(
    .SRC_W(SRC_W), .PC_BYTES(PC_BYTES), .SP_W(SP_W),
    .LONG_JUMP(LONG_JUMP), .VEC_BASE(VEC_BASE)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pcIn(pcIn), .spIn(spIn),
    .pendIn(pendIn), .anyPend(anyPend), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .pcLoad(pcLoad), .pcOut(pcOut), .spOut(spOut),
    .gieClr(gieClr), .pendClr(pendClr)
  );

endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resetReq = 1'b0, hwReq = 1'b0, gieIn = 1'b0;
  logic [31:0] pendIn = '0;
  logic [23:0] pcIn = '0;
  logic [15:0] spIn = '0;

  logic        busy[3], done[3], memWe[3], pcLoad[3], gieClr[3];
  logic [15:0] memAddr[3], spOut[3];
  logic [7:0]  memData[3];
  logic [23:0] pcOutX[3];
  logic [31:0] pendClr[3];

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  for (genvar g = 0; g < 3; g++) begin : g_dut
    localparam int PW = 8 * (g + 1);
    logic [PW-1:0] pcO;
    irq_entry_seq #(
      .PC_BYTES(g + 1), .LONG_JUMP(g != 0), .VEC_BASE((g == 1) ? 8 : 0)
    ) dut_i (
      .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .hwReq(hwReq),
      .gieIn(gieIn), .pendIn(pendIn), .pcIn(pcIn[PW-1:0]), .spIn(spIn),
      .busy(busy[g]), .done(done[g]), .memWe(memWe[g]), .memAddr(memAddr[g]),
      .memData(memData[g]), .pcLoad(pcLoad[g]), .pcOut(pcO),
      .spOut(spOut[g]), .gieClr(gieClr[g]), .pendClr(pendClr[g])
    );
    assign pcOutX[g] = 24'(pcO);
  end

  function automatic int baseOf(int d); return (d == 1) ? 8 : 0; endfunction
  function automatic int sizeOf(int d); return (d == 0) ? 1 : 2; endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle k after the acceptance edge, sampled at the negedge
  task automatic checkCycle(input int k, input logic [23:0] pc,
                            input logic [15:0] sp, input int vec,
                            input logic [31:0] clr, input bit isRst);
    for (int d = 0; d < 3; d++) begin
      int n = d + 1;
      if (k <= n) begin
        chk(memWe[d] == 1'b1, "R6", 32'(memWe[d]), 1);
        chk(memAddr[d] == sp - 16'(k - 1), "R5", 32'(memAddr[d]), 32'(sp - 16'(k - 1)));
        chk(memData[d] == pc[8*(k-1) +: 8], "R4", 32'(memData[d]), 32'(pc[8*(k-1) +: 8]));
        chk(busy[d] == 1'b1, "R10", 32'(busy[d]), 1);
        chk(done[d] == 1'b0, "R11", 32'(done[d]), 0);
      end else if (k == n + 1) begin
        logic [31:0] expPc;
        expPc = (32'(baseOf(d)) + 32'(vec) * 32'(sizeOf(d))) & ((32'd1 << (8 * n)) - 1);
        chk(memWe[d] == 1'b0, "R6", 32'(memWe[d]), 0);
        chk(done[d] && pcLoad[d], "R11", {done[d], pcLoad[d]}, 3);
        chk(gieClr[d] == 1'b1, "R7", 32'(gieClr[d]), 1);
        chk(busy[d] == 1'b1, "R10", 32'(busy[d]), 1);
        chk(32'(pcOutX[d]) == expPc, "R2 R3", 32'(pcOutX[d]), expPc);
        chk(spOut[d] == sp - 16'(n), "R5", 32'(spOut[d]), 32'(sp - 16'(n)));
        chk(pendClr[d] == clr, isRst ? "R9" : "R1", pendClr[d], clr);
      end else begin
        chk(!busy[d] && !memWe[d] && !done[d], "R10",
            {busy[d], memWe[d], done[d]}, 0);
        chk(pendClr[d] == '0 && !gieClr[d], "R7", pendClr[d], 0);
      end
    end
  endtask

  task automatic runEntry(input bit rst, input bit hw, input logic [31:0] pend,
                          input logic [23:0] pc, input logic [15:0] sp,
                          input bit disturb);
    int vec = 0;
    logic [31:0] clr = '0;
    if (!rst) begin
      for (int i = 31; i >= 0; i--) if (pend[i]) begin vec = i + 1; clr = 32'd1 << i; end
    end
    @(negedge clk);
    resetReq = rst; hwReq = hw; gieIn = 1'b1; pendIn = pend; pcIn = pc; spIn = sp;
    @(posedge clk);
    @(negedge clk);
    if (disturb) begin
      resetReq = 1'b1; hwReq = 1'b1; pendIn = 32'h1; pcIn = ~pc; spIn = ~sp;
    end else begin
      resetReq = 1'b0; hwReq = 1'b0;
    end
    checkCycle(1, pc, sp, vec, clr, rst);
    @(negedge clk);
    resetReq = 1'b0; hwReq = 1'b0;
    checkCycle(2, pc, sp, vec, clr, rst);
    for (int k = 3; k <= 5; k++) begin
      @(negedge clk);
      checkCycle(k, pc, sp, vec, clr, rst);
    end
  endtask

  task automatic noAccept(input bit rst, input bit hw, input bit gie,
                          input logic [31:0] pend);
    @(negedge clk);
    resetReq = rst; hwReq = hw; gieIn = gie; pendIn = pend;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      for (int d = 0; d < 3; d++)
        chk(!busy[d] && !memWe[d], "R8", {busy[d], memWe[d]}, 0);
    end
    resetReq = 1'b0; hwReq = 1'b0;
  endtask

  task automatic t_resetState();
    @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(!busy[d] && !done[d] && !memWe[d] && !pcLoad[d] && !gieClr[d] &&
          pendClr[d] == '0, "R11", {busy[d], done[d], memWe[d]}, 0);
  endtask

  task automatic t_singleSource();   runEntry(0, 1, 32'h0000_0001, 24'h12_3456, 16'h08FF, 0); endtask  // R2
  task automatic t_priority();       runEntry(0, 1, 32'h00A0_0010, 24'hAB_CDEF, 16'h1000, 0); endtask  // R1
  task automatic t_topSource();      runEntry(0, 1, 32'h8000_0000, 24'h7F_0102, 16'h0003, 0); endtask  // R2 R3
  task automatic t_resetWins();      runEntry(1, 1, 32'h0000_0300, 24'h55_AA33, 16'h2222, 0); endtask  // R9
  task automatic t_busyIgnore();     runEntry(0, 1, 32'h0000_0040, 24'h0F_1E2D, 16'h4000, 1); endtask  // R10

  task automatic t_blocked();
    noAccept(0, 1, 0, 32'h0000_0005);  // R8 enable low
    noAccept(1, 0, 0, 32'h0);          // R9 reset also needs enable
    noAccept(0, 1, 1, 32'h0);          // R8 nothing pending
    noAccept(0, 0, 1, 32'hFFFF_FFFF);  // R8 no request
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_resetState();
    @(negedge clk);
    rst_n = 1'b1;
    t_resetState();
    t_singleSource();
    t_priority();
    t_topSource();
    t_resetWins();
    t_blocked();
    t_busyIgnore();
    t_priority();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule